// File: doc/BRIEF.md
# Planar Geometry Mode Engine

A clocked integer coordinate-geometry unit. A job starts when `in_valid` is high while the unit is idle. On that edge it captures four points and a mode code. Three job types exist, and each reads the four points in its own way.

The first job type is trapezoid rasterisation. The unit walks a scan box and flags every integer pixel that lies inside a trapezoid with horizontal top and bottom edges. The second is circle/line classification. The circle is given by its center and one point on its rim, and the line by two of its points. The unit reports whether the line touches, crosses or misses the circle, using only exact integer arithmetic. The third is the area of a four-vertex polygon, computed with the shoelace sum.

A one-cycle `done` pulse ends every job. The relationship code and the area stay on their ports until a later job of the same kind replaces them.

Points are packed four to a bus: point k sits in bits `[k*CW +: CW]` of `pts_x` and `pts_y`. All coordinates are unsigned integers.

Top module: `geo_mode_engine`

## Requirements
- R1: After reset, `busy`, `done` and `pix_valid` are 0, and `rel_code` and `area` are 0.
- R2: A job is accepted when `in_valid` is 1, `busy` is 0 and `mode` is 0 (raster), 1 (classify) or 2 (area). `busy` is 1 in the following cycle. Any `in_valid` seen while `busy` is 1 is ignored: it alters neither the pixel stream nor the held results.
- R3: `mode` = 3 is reserved. An `in_valid` carrying it starts nothing: `busy` and `done` stay 0, and `rel_code` and `area` keep their values.
- R4: Raster mode reads point 0 as bottom-left (xbl,yb), point 1 as bottom-right (xbr,yb), point 2 as top-left (xtl,yt) and point 3 as top-right (xtr,yt). The caller guarantees yt >= yb, xbl <= xbr and xtl <= xtr. The scan box covers rows yb..yt and columns min(xbl,xtl)..max(xbr,xtr). A pixel (x,y) in that box is emitted exactly when both of the following hold: (xtl-xbl)(y-yb) - (yt-yb)(x-xbl) <= 0, and (xtr-xbr)(y-yb) - (yt-yb)(x-xbr) >= 0. When yt = yb, the whole one-row box is emitted.
- R5: The unit visits one box position per cycle, rows from bottom to top and columns left to right within each row. `pix_valid` marks each emitted position, and `pix_x`/`pix_y` carry its coordinates.
- R6: A raster job raises `done` for one cycle, with `busy` low, exactly (rows × columns of the box) + 1 cycles after the accepting edge.
- R7: Classify mode reads point 0 as center C, point 1 as rim point P, and points 2 and 3 as line points A ≠ B. With r² = |P-C|², L² = |B-A|² and k = (Bx-Ax)(Cy-Ay) - (By-Ay)(Cx-Ax), `rel_code` becomes 1 (crossing) when k² < r²·L², 0 (miss) when k² > r²·L², and 2 (tangent) when they are equal. The code 3 never appears.
- R8: The tangent decision is exact: a line at a distance equal to the radius gives code 2, including vertical and horizontal lines and coordinates at the range limit.
- R9: Area mode sets `area` = floor(|S|/2). Here S is the sum over k of x_k·y_(k+1) - x_(k+1)·y_k, with indices taken modulo 4. Both vertex orientations give the same result.
- R10: A classify or area job raises `done` for one cycle, with `busy` low, exactly 2 cycles after its accepting edge. Its result is valid from that cycle on.
- R11: `rel_code` changes only in a cycle where `done` is 1 after a classify job, and `area` only in such a cycle after an area job. A job of another mode leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Job request |
| mode | input | 2 | 0 raster, 1 classify, 2 area, 3 reserved |
| pts_x | input | 4*CW | X coordinates of points 0..3 |
| pts_y | input | 4*CW | Y coordinates of points 0..3 |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| pix_valid | output | 1 | Current scan position is inside the trapezoid |
| pix_x | output | CW | Scan column |
| pix_y | output | CW | Scan row |
| rel_code | output | 2 | Circle/line result |
| area | output | 2*CW+1 | Polygon area, floored |

## Verification
The bench checks each emitted pixel against a queue built from the edge inequalities, in order, so a design that skipped edge pixels or visited rows top-down shows up as a mismatch. It covers slanted edges that move the scan box past the bottom edge, zero-height trapezoids, and coordinates at 63, where a narrowed product or sign extension would drop or invent pixels. For classification, directed tangent cases probe the exact-equality point: any rounding or truncated product would report a crossing or a miss instead. For area, odd shoelace sums and clockwise vertex order catch a design that rounds up or fails to take the absolute value. Requests raised mid-job and reserved-mode requests check that a design does not restart, corrupt the stream, or overwrite the held results.

// File: rtl/geo_pkg.sv
`timescale 1ns/1ps
package geo_pkg;
   typedef enum logic [1:0] {
      MODE_RASTER   = 2'd0,
      MODE_CLASSIFY = 2'd1,
      MODE_AREA     = 2'd2,
      MODE_RSVD     = 2'd3
   } geo_mode_e;

   localparam logic [1:0] REL_MISS  = 2'd0;
   localparam logic [1:0] REL_CROSS = 2'd1;
   localparam logic [1:0] REL_TOUCH = 2'd2;

   localparam int NPTS = 4;
endpackage

// File: rtl/geo_raster.sv
`timescale 1ns/1ps
module geo_raster #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] xbl_i,
   input  logic [CW-1:0] xbr_i,
   input  logic [CW-1:0] xtl_i,
   input  logic [CW-1:0] xtr_i,
   input  logic [CW-1:0] yb_i,
   input  logic [CW-1:0] yt_i,
   output logic          pix_valid,
   output logic [CW-1:0] pix_x,
   output logic [CW-1:0] pix_y,
   output logic          scan_last
);
   localparam int SW = 2*CW + 4;

   logic [CW-1:0] xbl, xbr, xtl, xtr, yb, yt;
   logic [CW-1:0] col_lo, col_hi, col_q, row_q;
   logic          active;

   function automatic logic signed [SW-1:0] sx(input logic [CW-1:0] v);
      return signed'({{(SW-CW){1'b0}}, v});
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xbl <= '0; xbr <= '0; xtl <= '0; xtr <= '0; yb <= '0; yt <= '0;
         col_lo <= '0; col_hi <= '0; col_q <= '0; row_q <= '0;
         active <= 1'b0;
      end else if (start) begin
         xbl    <= xbl_i;
         xbr    <= xbr_i;
         xtl    <= xtl_i;
         xtr    <= xtr_i;
         yb     <= yb_i;
         yt     <= yt_i;
         col_lo <= (xbl_i < xtl_i) ? xbl_i : xtl_i;
         col_hi <= (xbr_i > xtr_i) ? xbr_i : xtr_i;
         col_q  <= (xbl_i < xtl_i) ? xbl_i : xtl_i;
         row_q  <= yb_i;
         active <= 1'b1;
      end else if (active) begin
         if (col_q == col_hi) begin
            col_q <= col_lo;
            if (row_q == yt) active <= 1'b0;
            else             row_q  <= row_q + 1'b1;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   logic signed [SW-1:0] height, rise, left_k, right_k;

   always_comb begin
      height  = sx(yt) - sx(yb);
      rise    = sx(row_q) - sx(yb);
      left_k  = (sx(xtl) - sx(xbl)) * rise - height * (sx(col_q) - sx(xbl));
      right_k = (sx(xtr) - sx(xbr)) * rise - height * (sx(col_q) - sx(xbr));
   end

   assign pix_valid = active && (left_k <= 0) && (right_k >= 0);
   assign pix_x     = col_q;
   assign pix_y     = row_q;
   assign scan_last = active && (col_q == col_hi) && (row_q == yt);
endmodule

// File: rtl/geo_relate.sv
`timescale 1ns/1ps
module geo_relate #(
   parameter int CW = 6
) (
   input  logic [CW-1:0] cx,
   input  logic [CW-1:0] cy,
   input  logic [CW-1:0] rx,
   input  logic [CW-1:0] ry,
   input  logic [CW-1:0] ax,
   input  logic [CW-1:0] ay,
   input  logic [CW-1:0] bx,
   input  logic [CW-1:0] by,
   output logic [1:0]    code
);
   import geo_pkg::*;
   localparam int PW = 4*CW + 4;

   function automatic logic signed [PW-1:0] sx(input logic [CW-1:0] v);
      return signed'({{(PW-CW){1'b0}}, v});
   endfunction

   logic signed [PW-1:0] rad2, len2, dxl, dyl, kx, lhs, rhs;

   always_comb begin
      rad2 = (sx(rx) - sx(cx)) * (sx(rx) - sx(cx)) + (sx(ry) - sx(cy)) * (sx(ry) - sx(cy));
      dxl  = sx(bx) - sx(ax);
      dyl  = sx(by) - sx(ay);
      len2 = dxl * dxl + dyl * dyl;
      kx   = dxl * (sx(cy) - sx(ay)) - dyl * (sx(cx) - sx(ax));
      lhs  = kx * kx;
      rhs  = rad2 * len2;
      if (lhs < rhs)       code = REL_CROSS;
      else if (lhs == rhs) code = REL_TOUCH;
      else                 code = REL_MISS;
   end
endmodule

// File: rtl/geo_shoelace.sv
`timescale 1ns/1ps
module geo_shoelace #(
   parameter int CW = 6,
   parameter int NV = 4
) (
   input  logic [NV*CW-1:0] xs,
   input  logic [NV*CW-1:0] ys,
   output logic [2*CW:0]    area
);
   localparam int SW = 2*CW + 4;

   logic signed [SW-1:0] term [NV];

   for (genvar k = 0; k < NV; k++) begin : g_term
      localparam int NX = (k + 1) % NV;
      logic signed [SW-1:0] xa, ya, xb, yb;
      assign xa = signed'({{(SW-CW){1'b0}}, xs[k*CW +: CW]});
      assign ya = signed'({{(SW-CW){1'b0}}, ys[k*CW +: CW]});
      assign xb = signed'({{(SW-CW){1'b0}}, xs[NX*CW +: CW]});
      assign yb = signed'({{(SW-CW){1'b0}}, ys[NX*CW +: CW]});
      assign term[k] = xa * yb - xb * ya;
   end

   logic signed [SW-1:0] total, mag;

   always_comb begin
      total = '0;
      for (int k = 0; k < NV; k++) total = total + term[k];
      mag  = (total < 0) ? -total : total;
      area = mag[2*CW+1:1];
   end
endmodule

// File: rtl/geo_mode_engine.sv
`timescale 1ns/1ps
module geo_mode_engine #(
   parameter int CW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        mode,
   input  logic [4*CW-1:0]   pts_x,
   input  logic [4*CW-1:0]   pts_y,
   output logic              busy,
   output logic              done,
   output logic              pix_valid,
   output logic [CW-1:0]     pix_x,
   output logic [CW-1:0]     pix_y,
   output logic [1:0]        rel_code,
   output logic [2*CW:0]     area
);
   import geo_pkg::*;
   localparam int AW = 2*CW + 1;

   if (CW < 2 || CW > 16) begin : g_cw_check
      $error("geo_mode_engine: CW must lie in 2..16");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_CALC} st_e;
   st_e st;

   logic [4*CW-1:0] xq, yq;
   geo_mode_e       mode_q;
   logic            accept, scan_last;
   logic [1:0]      code_c;
   logic [AW-1:0]   area_c;

   assign accept = in_valid && (st == ST_IDLE) && (geo_mode_e'(mode) != MODE_RSVD);

   geo_raster #(.CW(CW)) u_raster (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept && (geo_mode_e'(mode) == MODE_RASTER)),
      .xbl_i     (pts_x[0*CW +: CW]),
      .xbr_i     (pts_x[1*CW +: CW]),
      .xtl_i     (pts_x[2*CW +: CW]),
      .xtr_i     (pts_x[3*CW +: CW]),
      .yb_i      (pts_y[0*CW +: CW]),
      .yt_i      (pts_y[2*CW +: CW]),
      .pix_valid (pix_valid),
      .pix_x     (pix_x),
      .pix_y     (pix_y),
      .scan_last (scan_last)
   );

   geo_relate #(.CW(CW)) u_relate (
      .cx   (xq[0*CW +: CW]), .cy (yq[0*CW +: CW]),
      .rx   (xq[1*CW +: CW]), .ry (yq[1*CW +: CW]),
      .ax   (xq[2*CW +: CW]), .ay (yq[2*CW +: CW]),
      .bx   (xq[3*CW +: CW]), .by (yq[3*CW +: CW]),
      .code (code_c)
   );

   geo_shoelace #(.CW(CW), .NV(NPTS)) u_area (
      .xs   (xq),
      .ys   (yq),
      .area (area_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         xq       <= '0;
         yq       <= '0;
         mode_q   <= MODE_RASTER;
         done     <= 1'b0;
         rel_code <= REL_MISS;
         area     <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (accept) begin
               xq     <= pts_x;
               yq     <= pts_y;
               mode_q <= geo_mode_e'(mode);
               st     <= (geo_mode_e'(mode) == MODE_RASTER) ? ST_SCAN : ST_CALC;
            end
            ST_SCAN: if (scan_last) begin
               st   <= ST_IDLE;
               done <= 1'b1;
            end
            ST_CALC: begin
               if (mode_q == MODE_CLASSIFY) rel_code <= code_c;
               else                         area     <= area_c;
               done <= 1'b1;
               st   <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);
endmodule

// File: rtl/geo_mode_engine_chk.sv
`timescale 1ns/1ps
module geo_mode_engine_chk #(
   parameter int CW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    mode,
   input logic          busy,
   input logic          done,
   input logic          pix_valid,
   input logic [1:0]    rel_code,
   input logic [2*CW:0] area
);
   AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy && mode != 2'd3) |=> busy); // R2
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !busy && mode == 2'd3) |=> (!busy && !done)); // R3
   AST_PIX_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> busy); // R5
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
   AST_REL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rel_code != 2'd3); // R7
   AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rel_code) |-> done); // R11
   AST_AREA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(area) |-> done); // R11
endmodule

bind geo_mode_engine geo_mode_engine_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .mode      (mode),
   .busy      (busy),
   .done      (done),
   .pix_valid (pix_valid),
   .rel_code  (rel_code),
   .area      (area)
);

// File: tb/tb_geo_mode_engine.sv
`timescale 1ns/1ps
module tb_geo_mode_engine;
   localparam int CW = 6;
   localparam int AW = 2*CW + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [1:0]      mode = 2'd0;
   logic [4*CW-1:0] pts_x = '0;
   logic [4*CW-1:0] pts_y = '0;
   logic            busy, done, pix_valid;
   logic [CW-1:0]   pix_x, pix_y;
   logic [1:0]      rel_code;
   logic [AW-1:0]   area;

   int n_cmp = 0;
   int n_bad = 0;
   int ex_x[$];
   int ex_y[$];

   always #2.5 clk = ~clk;

   geo_mode_engine #(.CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .pts_x(pts_x), .pts_y(pts_y), .busy(busy), .done(done),
      .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
      .rel_code(rel_code), .area(area)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void put_pts(input int x0, y0, x1, y1, x2, y2, x3, y3);
      pts_x = {CW'(x3), CW'(x2), CW'(x1), CW'(x0)};
      pts_y = {CW'(y3), CW'(y2), CW'(y1), CW'(y0)};
   endfunction

   function automatic int ref_relate(input int cx, cy, px, py, ax, ay, bx, by);
      longint r2, l2, k, lhs, rhs;
      r2  = longint'((px-cx)*(px-cx) + (py-cy)*(py-cy));
      l2  = longint'((bx-ax)*(bx-ax) + (by-ay)*(by-ay));
      k   = longint'((bx-ax)*(cy-ay) - (by-ay)*(cx-ax));
      lhs = k*k;
      rhs = r2*l2;
      if (lhs < rhs) return 1;
      if (lhs == rhs) return 2;
      return 0;
   endfunction

   function automatic int ref_area(input int x0, y0, x1, y1, x2, y2, x3, y3);
      int s;
      s = (x0*y1 - x1*y0) + (x1*y2 - x2*y1) + (x2*y3 - x3*y2) + (x3*y0 - x0*y3);
      if (s < 0) s = -s;
      return s / 2;
   endfunction

   // builds the expected pixel queue (R4, R5) and returns the box size
   function automatic int ref_raster(input int xbl, xbr, xtl, xtr, yb, yt);
      int lo, hi;
      lo = (xbl < xtl) ? xbl : xtl;
      hi = (xbr > xtr) ? xbr : xtr;
      ex_x.delete();
      ex_y.delete();
      for (int y = yb; y <= yt; y++)
         for (int x = lo; x <= hi; x++)
            if (((xtl-xbl)*(y-yb) - (yt-yb)*(x-xbl) <= 0) &&
                ((xtr-xbr)*(y-yb) - (yt-yb)*(x-xbr) >= 0)) begin
               ex_x.push_back(x);
               ex_y.push_back(y);
            end
      return (yt-yb+1)*(hi-lo+1);
   endfunction

   // starts a job at a negedge, samples at negedges, returns edges to done
   task automatic run_job(input int md, input bit poke, output int cyc);
      int x0, y0;
      @(negedge clk);
      mode = 2'(md);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      cyc = 1;
      while (!done && cyc < 6000) begin
         if (busy == 1'b0) check(1'b0, "R2", "busy after accept", 0, 1);
         if (pix_valid) begin
            if (ex_x.size() == 0) begin
               check(1'b0, "R4", "unexpected pixel x", pix_x, -1);
            end else begin
               x0 = ex_x.pop_front();
               y0 = ex_y.pop_front();
               check(pix_x == CW'(x0) && pix_y == CW'(y0), "R5", "pixel x*64+y",
                     pix_x*64 + pix_y, x0*64 + y0);
            end
         end
         if (poke && cyc == 2) begin
            mode = 2'd2;
            put_pts(63, 63, 0, 0, 63, 0, 0, 63);
            in_valid = 1'b1;
         end else begin
            in_valid = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      in_valid = 1'b0;
      check(done == 1'b1, "R6", "done reached", done, 1);
      check(busy == 1'b0, "R6", "busy with done", busy, 0);
   endtask

   task automatic do_raster(input int xbl, xbr, xtl, xtr, yb, yt, input bit poke);
      int box, cyc, hold_rel, hold_area;
      box = ref_raster(xbl, xbr, xtl, xtr, yb, yt);
      hold_rel  = rel_code;
      hold_area = area;
      put_pts(xbl, yb, xbr, yb, xtl, yt, xtr, yt);
      run_job(0, poke, cyc);
      check(ex_x.size() == 0, "R4", "missing pixels", ex_x.size(), 0);
      check(cyc == box + 1, "R6", "raster latency", cyc, box + 1);
      check(rel_code == 2'(hold_rel) && area == AW'(hold_area), "R11",
            "results held across raster", area, hold_area);
   endtask

   task automatic do_relate(input int cx, cy, px, py, ax, ay, bx, by, input string req);
      int cyc, exp, hold_area;
      exp = ref_relate(cx, cy, px, py, ax, ay, bx, by);
      hold_area = area;
      ex_x.delete();
      ex_y.delete();
      put_pts(cx, cy, px, py, ax, ay, bx, by);
      run_job(1, 1'b0, cyc);
      check(cyc == 2, "R10", "classify latency", cyc, 2);
      check(rel_code == 2'(exp), req, "rel_code", rel_code, exp);
      check(area == AW'(hold_area), "R11", "area held over classify", area, hold_area);
   endtask

   task automatic do_area(input int x0, y0, x1, y1, x2, y2, x3, y3);
      int cyc, exp, hold_rel;
      exp = ref_area(x0, y0, x1, y1, x2, y2, x3, y3);
      hold_rel = rel_code;
      ex_x.delete();
      ex_y.delete();
      put_pts(x0, y0, x1, y1, x2, y2, x3, y3);
      run_job(2, 1'b0, cyc);
      check(cyc == 2, "R10", "area latency", cyc, 2);
      check(area == AW'(exp), "R9", "area", area, exp);
      check(rel_code == 2'(hold_rel), "R11", "rel held over area", rel_code, hold_rel);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int seed, a, b, c, d, e, f, g, h;
      seed = $urandom(32'd7719);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check(busy == 0 && done == 0 && pix_valid == 0, "R1", "control flags", {busy, done, pix_valid}, 0);
      check(rel_code == 0 && area == 0, "R1", "result regs", area + rel_code, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4/R5 directed rasters
      do_raster(2, 5, 2, 5, 3, 5, 1'b0);          // rectangle
      do_raster(0, 10, 5, 5, 0, 5, 1'b0);         // apex trapezoid
      do_raster(4, 9, 1, 12, 7, 10, 1'b0);        // widening top
      do_raster(3, 8, 6, 6, 20, 20, 1'b0);        // zero height
      do_raster(60, 63, 61, 63, 58, 63, 1'b0);    // range limit

      // R8 directed tangents, R7 crossing and miss
      do_relate(10, 10, 10, 15, 0, 5, 20, 5, "R8");
      do_relate(10, 10, 13, 14, 15, 0, 15, 30, "R8");
      do_relate(63, 63, 63, 0, 0, 0, 0, 63, "R8");
      do_relate(10, 10, 10, 15, 0, 7, 20, 7, "R7");
      do_relate(10, 10, 10, 15, 0, 30, 20, 30, "R7");
      do_relate(0, 0, 3, 4, 5, 0, 0, 5, "R7");

      // R9 directed areas
      do_area(0, 0, 63, 0, 63, 63, 0, 63);
      do_area(0, 63, 63, 63, 63, 0, 0, 0);
      do_area(0, 0, 3, 0, 0, 1, 0, 1);
      do_area(5, 5, 5, 5, 5, 5, 5, 5);

      // R2 request while busy is ignored
      do_raster(1, 6, 2, 5, 1, 4, 1'b1);

      // R3 reserved mode
      begin
         int hr, ha;
         hr = rel_code;
         ha = area;
         @(negedge clk);
         mode = 2'd3;
         put_pts(1, 2, 3, 4, 5, 6, 7, 8);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         for (int k = 0; k < 3; k++) begin
            check(busy == 0 && done == 0, "R3", "reserved start", {busy, done}, 0);
            @(negedge clk);
         end
         check(rel_code == 2'(hr) && area == AW'(ha), "R3", "results after reserved", area, ha);
      end

      // random rasters
      for (int n = 0; n < 30; n++) begin
         a = $urandom_range(0, 40);
         b = a + $urandom_range(0, 10);
         c = a + $urandom_range(0, 8) - 4;
         if (c < 0) c = 0;
         d = c + $urandom_range(0, 10);
         e = $urandom_range(0, 50);
         f = e + $urandom_range(0, 8);
         do_raster(a, b, c, d, e, f, 1'b0);
      end
      // random classifications (small range raises tie odds)
      for (int n = 0; n < 120; n++) begin
         int lim;
         lim = (n % 2 == 0) ? 12 : 63;
         a = $urandom_range(0, lim); b = $urandom_range(0, lim);
         c = $urandom_range(0, lim); d = $urandom_range(0, lim);
         e = $urandom_range(0, lim); f = $urandom_range(0, lim);
         g = $urandom_range(0, lim); h = $urandom_range(0, lim);
         if (e == g && f == h) g = (g + 1) % (lim + 1);
         do_relate(a, b, c, d, e, f, g, h, "R7");
      end
      // random areas
      for (int n = 0; n < 120; n++) begin
         do_area($urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 63),
                 $urandom_range(0, 63), $urandom_range(0, 63), $urandom_range(0, 63),
                 $urandom_range(0, 63), $urandom_range(0, 63));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule